// File: doc/BRIEF.md
# Sum-to-Booth Digit Recoder

This block takes two N-bit operands and emits the radix-4 Booth digits of their sum without ever building the sum itself. No carry-propagate adder sits in front of the encoder. Instead, each two-bit slice of the operands feeds a small local cell. The cell first passes the AND of the slice's top bits up to the next slice. It then folds its own low-bit carry into a redundant odd position, and that position resolves into a negatively weighted bit plus a single carry into the next digit. Every digit is drawn from {-2,-1,0,+1,+2}, and no carry travels further than one digit. The block is meant to sit in front of the partial-product selector of a multiplier that computes X*(A+B).

The parameter `SIGNED_OPS` selects how the operands are read: two's complement or unsigned. Odd and even `N` are both supported. In signed mode the most significant operand bits enter negative-weight cells. There is a pair cell for even `N` and a lone-bit cell for odd `N`. In unsigned mode, odd widths are zero-padded to an even width, and one extra top digit collects the final carry. Each digit leaves on three lines: a sign, a magnitude-one select and a magnitude-two select.

Top module: `sum_booth_recoder`

## Requirements
- R1: Digit k sits on bit k of `neg_o`, `one_o` and `two_o`. Its value is (neg ? -1 : +1) * (two ? 2 : one ? 1 : 0), and `one_o` and `two_o` are never high on the same digit.
- R2: A zero digit is encoded with all three lines low. `neg_o` is never high unless `one_o` or `two_o` is high on that digit.
- R3: With SIGNED_OPS=0, the sum over k of digit_k * 4^k equals the unsigned A+B exactly, for every operand pair, for both odd and even N. There are ceil(N/2)+1 digits.
- R4: With SIGNED_OPS=1, the sum over k of digit_k * 4^k equals the two's-complement A+B exactly, for every operand pair, for both odd and even N. There are floor((N+2)/2) digits.
- R5: With SIGNED_OPS=0, the most significant digit is never negative.
- R6: Digit 0 lies in {-2,-1,0,+1} and is congruent to A+B modulo 4.
- R7: Digit k depends only on operand bits 2k-3 through 2k+1. Changing operand bits at positions 2k+2 and above, or 2k-4 and below, leaves digit k unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | N | First addend |
| b_i | input | N | Second addend |
| neg_o | output | D | Per-digit sign (1 = negative) |
| one_o | output | D | Per-digit magnitude-one select |
| two_o | output | D | Per-digit magnitude-two select |

## Verification
The hardest condition to reach is a long carry chain, such as all-ones plus one. A ripple in the recoder would only show up there, and only as a wrong digit far above the bits that were changed. An exhaustive sweep of every operand pair, at an even and an odd width in both signed modes, reaches every such chain. A separate scan applies pseudo-random flips to operand bits outside each digit's five-bit window and confirms that the digit does not move.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

  typedef struct packed {
    logic neg;
    logic one;
    logic two;
  } bdig_t;

  function automatic int unsigned digit_count(input int unsigned n, input bit sgn);
    return sgn ? (n + 2) / 2 : (n + 1) / 2 + 1;
  endfunction

  // ordinary two-bit cells below the sign cell (signed) or covering the padded width
  function automatic int unsigned pair_count(input int unsigned n, input bit sgn);
    if (!sgn) return (n + 1) / 2;
    return (n % 2 == 0) ? n / 2 - 1 : n / 2;
  endfunction

endpackage

// File: rtl/sbr_pair_cell.sv
module sbr_pair_cell (
  input  logic [1:0] a_i,
  input  logic [1:0] b_i,
  input  logic       h_i,
  output logic       e_o,
  output logic       n_o,
  output logic       c_o,
  output logic       h_o
);
  logic k;
  logic l_hi;

  assign e_o  = a_i[0] ^ b_i[0] ^ h_i;
  assign k    = (a_i[0] & b_i[0]) | (h_i & (a_i[0] ^ b_i[0]));
  assign l_hi = a_i[1] ^ b_i[1];
  // l_hi + k == 2*c - n
  assign n_o  = l_hi ^ k;
  assign c_o  = l_hi | k;
  assign h_o  = a_i[1] & b_i[1];
endmodule

// File: rtl/sbr_neg_pair.sv
module sbr_neg_pair (
  input  logic [1:0] a_i,
  input  logic [1:0] b_i,
  input  logic       h_i,
  output logic       e_o,
  output logic       n_o,
  output logic       cp_o,
  output logic       cn_o
);
  logic k;

  assign e_o  = a_i[0] ^ b_i[0] ^ h_i;
  assign k    = (a_i[0] & b_i[0]) | (h_i & (a_i[0] ^ b_i[0]));
  // odd position carries k - a1 - b1 in [-2,1]
  assign n_o  = k ^ a_i[1] ^ b_i[1];
  assign cp_o = k & ~a_i[1] & ~b_i[1];
  assign cn_o = ~k & a_i[1] & b_i[1];
endmodule

// File: rtl/sbr_neg_bit.sv
module sbr_neg_bit (
  input  logic a_i,
  input  logic b_i,
  input  logic h_i,
  output logic e_o,
  output logic n_o
);
  // h - a - b == -2*n + e
  assign e_o = a_i ^ b_i ^ h_i;
  assign n_o = (a_i & b_i) | (~h_i & (a_i | b_i));
endmodule

// File: rtl/sbr_digit_enc.sv
module sbr_digit_enc
  import sbr_pkg::*;
(
  input  logic  hi_i,
  input  logic  mid_i,
  input  logic  lo_i,
  output bdig_t dig_o
);
  assign dig_o.neg = hi_i & ~(mid_i & lo_i);
  assign dig_o.one = mid_i ^ lo_i;
  assign dig_o.two = (hi_i & ~mid_i & ~lo_i) | (~hi_i & mid_i & lo_i);
endmodule

// File: rtl/sum_booth_recoder.sv
module sum_booth_recoder
  import sbr_pkg::*;
#(
  parameter  int unsigned N          = 8,
  parameter  bit          SIGNED_OPS = 1'b0,
  localparam int unsigned D          = digit_count(N, SIGNED_OPS),
  localparam int unsigned NP         = pair_count(N, SIGNED_OPS)
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  output logic [D-1:0] neg_o,
  output logic [D-1:0] one_o,
  output logic [D-1:0] two_o
);
  localparam int unsigned PW = 2 * NP;

  logic [PW-1:0] pa;
  logic [PW-1:0] pb;
  logic [NP:0]   h_c;
  logic [NP:0]   c_c;
  logic [D-1:0]  t_hi;
  logic [D-1:0]  t_mid;
  logic [D-1:0]  t_lo;

  assign h_c[0] = 1'b0;
  assign c_c[0] = 1'b0;

  if (PW > N) begin : g_pad
    assign pa = {{(PW - N){1'b0}}, a_i};
    assign pb = {{(PW - N){1'b0}}, b_i};
  end else begin : g_nopad
    assign pa = a_i[PW-1:0];
    assign pb = b_i[PW-1:0];
  end

  for (genvar j = 0; j < NP; j++) begin : g_pair
    logic e;
    logic n;
    sbr_pair_cell u_cell (
      .a_i (pa[2*j+1:2*j]),
      .b_i (pb[2*j+1:2*j]),
      .h_i (h_c[j]),
      .e_o (e),
      .n_o (n),
      .c_o (c_c[j+1]),
      .h_o (h_c[j+1])
    );
    assign t_hi[j]  = n;
    assign t_mid[j] = e;
    assign t_lo[j]  = c_c[j];
  end

  if (!SIGNED_OPS) begin : g_uns
    // top digit collects final AND carry and cell carry
    assign t_hi[NP]  = 1'b0;
    assign t_mid[NP] = h_c[NP];
    assign t_lo[NP]  = c_c[NP];
  end else if (N % 2 == 0) begin : g_sgn_even
    logic e;
    logic n;
    logic cp;
    logic cn;
    sbr_neg_pair u_top (
      .a_i  (a_i[N-1:N-2]),
      .b_i  (b_i[N-1:N-2]),
      .h_i  (h_c[NP]),
      .e_o  (e),
      .n_o  (n),
      .cp_o (cp),
      .cn_o (cn)
    );
    assign t_hi[NP]    = n;
    assign t_mid[NP]   = e;
    assign t_lo[NP]    = c_c[NP];
    assign t_hi[NP+1]  = cn;
    assign t_mid[NP+1] = 1'b0;
    assign t_lo[NP+1]  = cp | cn;
  end else begin : g_sgn_odd
    logic e;
    logic n;
    sbr_neg_bit u_top (
      .a_i (a_i[N-1]),
      .b_i (b_i[N-1]),
      .h_i (h_c[NP]),
      .e_o (e),
      .n_o (n)
    );
    assign t_hi[NP]  = n;
    assign t_mid[NP] = e;
    assign t_lo[NP]  = c_c[NP];
  end

  for (genvar k = 0; k < D; k++) begin : g_enc
    bdig_t d;
    sbr_digit_enc u_enc (
      .hi_i  (t_hi[k]),
      .mid_i (t_mid[k]),
      .lo_i  (t_lo[k]),
      .dig_o (d)
    );
    assign neg_o[k] = d.neg;
    assign one_o[k] = d.one;
    assign two_o[k] = d.two;
  end
endmodule

// File: rtl/sum_booth_recoder_chk.sv
module sum_booth_recoder_chk #(
  parameter  int unsigned N          = 8,
  parameter  bit          SIGNED_OPS = 1'b0,
  localparam int unsigned D          = sbr_pkg::digit_count(N, SIGNED_OPS)
) (
  input logic [N-1:0] a_i,
  input logic [N-1:0] b_i,
  input logic [D-1:0] neg_o,
  input logic [D-1:0] one_o,
  input logic [D-1:0] two_o
);
  localparam int unsigned VW = N + 6;

  function automatic logic signed [VW-1:0] dig_val(input logic n, input logic o, input logic t);
    logic signed [VW-1:0] v;
    v = t ? VW'(2) : (o ? VW'(1) : VW'(0));
    return n ? -v : v;
  endfunction

  logic signed [VW-1:0] acc;
  logic signed [VW-1:0] want;
  logic signed [VW-1:0] low_val;

  always_comb begin
    acc = '0;
    for (int k = 0; k < D; k++) begin
      acc = acc + (dig_val(neg_o[k], one_o[k], two_o[k]) <<< (2 * k));
    end
  end

  assign low_val = dig_val(neg_o[0], one_o[0], two_o[0]);

  always_comb begin
    AST_MAG_EXCLUSIVE: assert ((one_o & two_o) == '0); // R1
    AST_ZERO_POSITIVE: assert ((neg_o & ~(one_o | two_o)) == '0); // R2
    AST_LOW_RANGE: assert (!(two_o[0] && !neg_o[0])); // R6
    AST_LOW_MOD4: assert (low_val[1:0] == want[1:0]); // R6
  end

  if (SIGNED_OPS) begin : g_sgn
    assign want = {{6{a_i[N-1]}}, a_i} + {{6{b_i[N-1]}}, b_i};
    always_comb begin
      AST_SUM_SIGNED: assert (acc == want); // R4
    end
  end else begin : g_uns
    assign want = {6'b0, a_i} + {6'b0, b_i};
    always_comb begin
      AST_SUM_UNSIGNED: assert (acc == want); // R3
      AST_TOP_NONNEG: assert (!neg_o[D-1]); // R5
    end
  end
endmodule

bind sum_booth_recoder sum_booth_recoder_chk #(
  .N          (N),
  .SIGNED_OPS (SIGNED_OPS)
) u_sum_booth_recoder_chk (
  .a_i   (a_i),
  .b_i   (b_i),
  .neg_o (neg_o),
  .one_o (one_o),
  .two_o (two_o)
);

// File: tb/sum_booth_recoder_bench.sv
module sum_booth_recoder_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  int  total = 0;
  int  bad   = 0;
  bit  done  = 1'b0;

  logic [7:0] a8 = '0, b8 = '0;
  logic [6:0] a7 = '0, b7 = '0;
  logic [4:0] nu8, ou8, tu8, ns8, os8, ts8, nu7, ou7, tu7;
  logic [3:0] ns7, os7, ts7;

  sum_booth_recoder #(.N(8), .SIGNED_OPS(1'b0)) u_sum_booth_recoder (
    .a_i(a8), .b_i(b8), .neg_o(nu8), .one_o(ou8), .two_o(tu8));
  sum_booth_recoder #(.N(8), .SIGNED_OPS(1'b1)) u_sum_booth_recoder_s8 (
    .a_i(a8), .b_i(b8), .neg_o(ns8), .one_o(os8), .two_o(ts8));
  sum_booth_recoder #(.N(7), .SIGNED_OPS(1'b0)) u_sum_booth_recoder_u7 (
    .a_i(a7), .b_i(b7), .neg_o(nu7), .one_o(ou7), .two_o(tu7));
  sum_booth_recoder #(.N(7), .SIGNED_OPS(1'b1)) u_sum_booth_recoder_s7 (
    .a_i(a7), .b_i(b7), .neg_o(ns7), .one_o(os7), .two_o(ts7));

  function automatic int dval(input logic n, input logic o, input logic t);
    int v;
    v = t ? 2 : (o ? 1 : 0);
    return n ? -v : v;
  endfunction

  function automatic int dsum(input int nd, input logic [4:0] n, input logic [4:0] o,
                              input logic [4:0] t);
    int s;
    s = 0;
    for (int k = 0; k < nd; k++) s += dval(n[k], o[k], t[k]) * (1 << (2 * k));
    return s;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d a8=%0h b8=%0h a7=%0h b7=%0h", req, act, exp, a8, b8, a7, b7);
    end
  endtask

  function automatic bit fmt_ok(input logic [4:0] n, input logic [4:0] o, input logic [4:0] t);
    return ((o & t) == 5'd0) && ((n & ~(o | t)) == 5'd0);
  endfunction

  // zero operands give all-low outputs
  task automatic t_zero();
    @(negedge clk);
    a8 = '0; b8 = '0; a7 = '0; b7 = '0;
    #1;
    chk("R1 zero u8", int'({nu8, ou8, tu8}), 0);
    chk("R1 zero s8", int'({ns8, os8, ts8}), 0);
    chk("R2 zero u7", int'({nu7, ou7, tu7}), 0);
    chk("R2 zero s7", int'({ns7, os7, ts7}), 0);
  endtask

  task automatic t_exhaustive();
    for (int i = 0; i < 65536; i++) begin
      int v0;
      @(negedge clk);
      a8 = i[15:8]; b8 = i[7:0];
      a7 = i[13:7]; b7 = i[6:0];
      #1;
      chk("R3 u8 value", dsum(5, nu8, ou8, tu8), int'(a8) + int'(b8));
      chk("R4 s8 value", dsum(5, ns8, os8, ts8), int'($signed(a8)) + int'($signed(b8)));
      chk("R1 format u8/s8", int'(fmt_ok(nu8, ou8, tu8) && fmt_ok(ns8, os8, ts8)), 1);
      chk("R5 u8 top sign", int'(nu8[4]), 0);
      v0 = dval(nu8[0], ou8[0], tu8[0]);
      chk("R6 u8 digit0", int'(v0 >= -2 && v0 <= 1 && (((v0 - int'(a8) - int'(b8)) & 3) == 0)), 1);
      v0 = dval(ns8[0], os8[0], ts8[0]);
      chk("R6 s8 digit0", int'(v0 >= -2 && v0 <= 1 &&
          (((v0 - int'($signed(a8)) - int'($signed(b8))) & 3) == 0)), 1);
      if (i < 16384) begin
        chk("R3 u7 value", dsum(5, nu7, ou7, tu7), int'(a7) + int'(b7));
        chk("R4 s7 value", dsum(4, {1'b0, ns7}, {1'b0, os7}, {1'b0, ts7}),
            int'($signed(a7)) + int'($signed(b7)));
        chk("R2 format u7/s7", int'(fmt_ok(nu7, ou7, tu7) &&
            fmt_ok({1'b0, ns7}, {1'b0, os7}, {1'b0, ts7})), 1);
        chk("R5 u7 top sign", int'(nu7[4]), 0);
      end
    end
  endtask

  task automatic t_corners();
    @(negedge clk);
    a8 = 8'hFF; b8 = 8'hFF; a7 = 7'h7F; b7 = 7'h7F;
    #1;
    chk("R3 u8 max+max", dsum(5, nu8, ou8, tu8), 510);
    chk("R3 u7 max+max", dsum(5, nu7, ou7, tu7), 254);
    chk("R5 u8 max top", int'(nu8[4]), 0);
    @(negedge clk);
    a8 = 8'h80; b8 = 8'h80; a7 = 7'h40; b7 = 7'h40;
    #1;
    chk("R4 s8 min+min", dsum(5, ns8, os8, ts8), -256);
    chk("R4 s7 min+min", dsum(4, {1'b0, ns7}, {1'b0, os7}, {1'b0, ts7}), -128);
    @(negedge clk);
    a8 = 8'hFF; b8 = 8'h01; a7 = 7'h7F; b7 = 7'h01;
    #1;
    chk("R4 s8 -1+1", dsum(5, ns8, os8, ts8), 0);
    chk("R3 u8 carry chain", dsum(5, nu8, ou8, tu8), 256);
    chk("R3 u7 carry chain", dsum(5, nu7, ou7, tu7), 128);
  endtask

  // flips outside the window 2k-3..2k+1 leave digit k unchanged
  task automatic t_locality();
    logic [31:0] r;
    r = 32'h1234_5679;
    for (int it = 0; it < 200; it++) begin
      for (int k = 0; k < 5; k++) begin
        logic [7:0] msk;
        logic [2:0] ref_u, ref_s;
        msk = 8'hFF << (2 * k + 2);
        if (2 * k - 3 > 0) msk = msk | ((8'd1 << (2 * k - 3)) - 8'd1);
        r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
        @(negedge clk);
        a8 = r[7:0]; b8 = r[15:8];
        #1;
        ref_u = {nu8[k], ou8[k], tu8[k]};
        ref_s = {ns8[k], os8[k], ts8[k]};
        a8 = a8 ^ (r[23:16] & msk);
        b8 = b8 ^ (r[31:24] & msk);
        #1;
        chk("R7 u8 locality", int'({nu8[k], ou8[k], tu8[k]}), int'(ref_u));
        chk("R7 s8 locality", int'({ns8[k], os8[k], ts8[k]}), int'(ref_s));
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    t_zero();
    t_corners();
    t_locality();
    t_exhaustive();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule